// File: doc/BRIEF.md
# Adapter Reset and Init Sequencer

This block brings the glue logic of a network adapter out of reset and back into it. It owns three 8-bit control registers: a reset register with three active-low reset-release bits (core, host interface, FIFO), an interrupt control register and a FIFO threshold register. A one-cycle command pulse starts a short script of register writes. An early-enable command releases only the core reset and then waits. An open command runs the full bring-up. A close command drops every reset at once.

The open script sets the core release bit and then clears all three release bits together. It holds that state for a parameterised number of cycles. It then releases core, host interface and FIFO in that order, one write each. It finishes by setting the system interrupt enable and the bus error enable, and by loading the FIFO threshold. Every write appears on a one-cycle strobe together with its address and data, and the register outputs follow one cycle later. A busy flag covers the whole script, and a one-cycle done pulse closes it.

Top module: `adapter_init_seq`

## Requirements
- R1: After reset, all three registers read 0 (every part held in reset), and busy and done are 0.
- R2: Early enable performs exactly one write to the reset register (address 0), which sets bit 0 (core release) and keeps the other bits. It then waits WAIT_CYCLES cycles, and done comes 2+WAIT_CYCLES cycles after the command is accepted.
- R3: Open first writes the reset register with bit 0 set. It then writes it with bits 2:0 cleared and issues no strobe for WAIT_CYCLES cycles, during which the reset register reads with bits 2:0 at 0.
- R4: After that wait, open releases the resets with three separate writes to address 0, on consecutive cycles: bit 0 (core), then bit 1 (host interface), then bit 2 (FIFO). Each write keeps the bits already set.
- R5: After the releases, open writes the interrupt control register (address 1) with bit 0 (system interrupt enable) and bit 1 (bus error enable) set.
- R6: The last write of open loads FIFO_LEVEL (default 30) into the threshold register (address 2). Done follows 8+WAIT_CYCLES cycles after acceptance, and the script has seven writes in all.
- R7: Close writes 0 to the reset register in the cycle after acceptance, and done follows one cycle later.
- R8: Busy rises on the edge that accepts a command and stays high through the one-cycle done pulse. It is low in the cycle after done.
- R9: A command that arrives while busy is ignored. When several command pulses arrive together while idle, close wins over open, and open wins over early enable.
- R10: Each strobe lasts one cycle per write, and the addressed register shows the strobed data from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_enable | input | 1 | Early-enable command pulse |
| cmd_open | input | 1 | Open (full bring-up) command pulse |
| cmd_close | input | 1 | Close (reset all) command pulse |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 2 | Write address: 0 reset, 1 interrupt control, 2 threshold |
| wr_data | output | DATA_W | Write data |
| rst_reg | output | DATA_W | Reset register (bits 0..2 active-low releases) |
| irq_ctrl | output | DATA_W | Interrupt control register |
| fifo_thr | output | DATA_W | FIFO threshold register |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle end-of-script pulse |

## Verification
The assertions assume that commands are single-cycle pulses and that a pulse arriving during a script is dropped. They do not assume that the sender avoids busy periods. The stimulus drives every command at the falling edge for exactly one cycle. It deliberately fires a close in the middle of an open, and fires simultaneous command pairs while idle, so the priority and ignore rules are exercised. The wait length stays at its default, so the timer is checked at its real bound.

// File: rtl/adapter_init_pkg.sv
package adapter_init_pkg;

   typedef enum logic [1:0] {
      CMD_ENABLE = 2'd0,
      CMD_OPEN   = 2'd1,
      CMD_CLOSE  = 2'd2
   } cmd_kind_e;

   typedef enum logic {
      OP_WRITE = 1'b0,
      OP_WAIT  = 1'b1
   } op_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RUN  = 2'd1,
      SQ_DONE = 2'd2
   } seq_state_e;

   localparam int REG_ADDR_W = 2;
   localparam int NUM_REGS   = 3;
   localparam logic [REG_ADDR_W-1:0] ADDR_RESET = 2'd0;
   localparam logic [REG_ADDR_W-1:0] ADDR_IRQ   = 2'd1;
   localparam logic [REG_ADDR_W-1:0] ADDR_THR   = 2'd2;

   typedef struct packed {
      op_e                   op;
      logic                  last;
      logic [REG_ADDR_W-1:0] addr;
   } step_ctl_t;

endpackage

// File: rtl/init_step_rom.sv
module init_step_rom
   import adapter_init_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int STEP_W     = 3,
   parameter int CHIP_BIT   = 0,
   parameter int HOST_BIT   = 1,
   parameter int FIFO_BIT   = 2,
   parameter int SINT_BIT   = 0,
   parameter int BERR_BIT   = 1,
   parameter int FIFO_LEVEL = 30
) (
   input  cmd_kind_e         kind,
   input  logic [STEP_W-1:0] step,
   input  logic [DATA_W-1:0] cur_rst,
   output step_ctl_t         ctl,
   output logic [DATA_W-1:0] data
);
   localparam logic [DATA_W-1:0] ONE     = DATA_W'(1);
   localparam logic [DATA_W-1:0] M_CHIP  = ONE << CHIP_BIT;
   localparam logic [DATA_W-1:0] M_HOST  = ONE << HOST_BIT;
   localparam logic [DATA_W-1:0] M_FIFO  = ONE << FIFO_BIT;
   localparam logic [DATA_W-1:0] M_ALL   = M_CHIP | M_HOST | M_FIFO;
   localparam logic [DATA_W-1:0] IRQ_VAL = (ONE << SINT_BIT) | (ONE << BERR_BIT);
   localparam logic [DATA_W-1:0] THR_VAL = DATA_W'(FIFO_LEVEL);

   always_comb begin
      ctl.op   = OP_WRITE;
      ctl.last = 1'b1;
      ctl.addr = ADDR_RESET;
      data     = '0;
      case (kind)
         CMD_ENABLE: begin
            if (step == '0) begin
               ctl.last = 1'b0;
               data     = cur_rst | M_CHIP;
            end else begin
               ctl.op = OP_WAIT;
            end
         end
         CMD_OPEN: begin
            ctl.last = 1'b0;
            case (step)
               STEP_W'(0): data = cur_rst | M_CHIP;
               STEP_W'(1): data = cur_rst & ~M_ALL;
               STEP_W'(2): ctl.op = OP_WAIT;
               STEP_W'(3): data = cur_rst | M_CHIP;
               STEP_W'(4): data = cur_rst | M_HOST;
               STEP_W'(5): data = cur_rst | M_FIFO;
               STEP_W'(6): begin
                  ctl.addr = ADDR_IRQ;
                  data     = IRQ_VAL;
               end
               default: begin
                  ctl.addr = ADDR_THR;
                  ctl.last = 1'b1;
                  data     = THR_VAL;
               end
            endcase
         end
         default: data = '0;
      endcase
   end
endmodule

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
   parameter int WAIT_CYCLES = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

   logic [CNT_W-1:0] cnt;

   assign expire = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || expire) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end

   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   assert_idle_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt == '0);
endmodule

// File: rtl/init_reg_bank.sv
module init_reg_bank
   import adapter_init_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_stb,
   input  logic [REG_ADDR_W-1:0]              wr_addr,
   input  logic [DATA_W-1:0]                  wr_data,
   output logic [NUM_REGS-1:0][DATA_W-1:0]    regs
);
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                        regs[g] <= '0;
         else if (wr_stb && wr_addr == REG_ADDR_W'(g))      regs[g] <= wr_data;
      end

      assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_stb && wr_addr == REG_ADDR_W'(g)) |=> regs[g] == $past(wr_data));
      assert_untouched_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_stb && wr_addr == REG_ADDR_W'(g)) |=> $stable(regs[g]));
   end
endmodule

// File: rtl/adapter_init_seq.sv
module adapter_init_seq
   import adapter_init_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int WAIT_CYCLES = 100,
   parameter int FIFO_LEVEL  = 30,
   parameter int CHIP_BIT    = 0,
   parameter int HOST_BIT    = 1,
   parameter int FIFO_BIT    = 2,
   parameter int SINT_BIT    = 0,
   parameter int BERR_BIT    = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_enable,
   input  logic                  cmd_open,
   input  logic                  cmd_close,
   output logic                  wr_stb,
   output logic [1:0]            wr_addr,
   output logic [DATA_W-1:0]     wr_data,
   output logic [DATA_W-1:0]     rst_reg,
   output logic [DATA_W-1:0]     irq_ctrl,
   output logic [DATA_W-1:0]     fifo_thr,
   output logic                  busy,
   output logic                  done
);
   localparam int STEP_W = 3;

   initial begin
      assert_cfg_wait_R2: assert (WAIT_CYCLES >= 1)
         else $error("WAIT_CYCLES must be at least 1");
      assert_cfg_bits_R4: assert (CHIP_BIT != HOST_BIT && HOST_BIT != FIFO_BIT &&
                                  CHIP_BIT != FIFO_BIT && FIFO_BIT < DATA_W &&
                                  CHIP_BIT < DATA_W && HOST_BIT < DATA_W)
         else $error("reset bit positions must be distinct and inside DATA_W");
      assert_cfg_irq_R5: assert (SINT_BIT != BERR_BIT && SINT_BIT < DATA_W && BERR_BIT < DATA_W)
         else $error("interrupt bit positions must be distinct and inside DATA_W");
      assert_cfg_level_R6: assert (FIFO_LEVEL >= 0 && FIFO_LEVEL < (1 << DATA_W))
         else $error("FIFO_LEVEL does not fit DATA_W");
   end

   seq_state_e          state;
   cmd_kind_e           kind;
   logic [STEP_W-1:0]   step;
   step_ctl_t           ctl;
   logic [DATA_W-1:0]   step_data;
   logic                expire;
   logic                advance;
   logic                any_cmd;
   cmd_kind_e           pick;
   logic [NUM_REGS-1:0][DATA_W-1:0] regs;

   init_step_rom #(
      .DATA_W(DATA_W), .STEP_W(STEP_W),
      .CHIP_BIT(CHIP_BIT), .HOST_BIT(HOST_BIT), .FIFO_BIT(FIFO_BIT),
      .SINT_BIT(SINT_BIT), .BERR_BIT(BERR_BIT), .FIFO_LEVEL(FIFO_LEVEL)
   ) u_rom (
      .kind(kind), .step(step), .cur_rst(rst_reg), .ctl(ctl), .data(step_data)
   );

   init_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .run(state == SQ_RUN && ctl.op == OP_WAIT),
      .expire(expire)
   );

   init_reg_bank #(.DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .regs(regs)
   );

   assign rst_reg  = regs[ADDR_RESET];
   assign irq_ctrl = regs[ADDR_IRQ];
   assign fifo_thr = regs[ADDR_THR];

   assign wr_stb  = (state == SQ_RUN) && (ctl.op == OP_WRITE);
   assign wr_addr = ctl.addr;
   assign wr_data = step_data;
   assign busy    = (state != SQ_IDLE);
   assign done    = (state == SQ_DONE);
   assign advance = (ctl.op == OP_WRITE) || expire;
   assign any_cmd = cmd_enable || cmd_open || cmd_close;

   always_comb begin
      if (cmd_close)     pick = CMD_CLOSE;
      else if (cmd_open) pick = CMD_OPEN;
      else               pick = CMD_ENABLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         kind  <= CMD_ENABLE;
         step  <= '0;
      end else begin
         case (state)
            SQ_IDLE: if (any_cmd) begin
               state <= SQ_RUN;
               kind  <= pick;
               step  <= '0;
            end
            SQ_RUN: if (advance) begin
               if (ctl.last) state <= SQ_DONE;
               else          step  <= step + 1'b1;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assert_done_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);
   assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (cmd_enable || cmd_open || cmd_close)) |=> busy);
   assert_close_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_close) |=> wr_stb && wr_addr == ADDR_RESET && wr_data == '0);
   assert_open_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_open && !cmd_close) |=> wr_stb && wr_addr == ADDR_RESET && wr_data[CHIP_BIT]);
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !wr_stb);
   assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(rst_reg));
endmodule

// File: tb/test_adapter_init_seq.sv
module test_adapter_init_seq;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 100;
   localparam int LVL        = 30;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_enable = 1'b0, cmd_open = 1'b0, cmd_close = 1'b0;
   logic       wr_stb, busy, done;
   logic [1:0] wr_addr;
   logic [7:0] wr_data, rst_reg, irq_ctrl, fifo_thr;

   int checks = 0;
   int errors = 0;
   int log_addr[16];
   int log_data[16];
   int log_cyc[16];
   int n_log;
   int cycles;
   int mid_rst;
   int busy_low;

   always #(CLK_PERIOD/2) clk = ~clk;

   adapter_init_seq #(.WAIT_CYCLES(W), .FIFO_LEVEL(LVL)) i_adapter_init_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_enable(cmd_enable), .cmd_open(cmd_open), .cmd_close(cmd_close),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .rst_reg(rst_reg), .irq_ctrl(irq_ctrl), .fifo_thr(fifo_thr),
      .busy(busy), .done(done)
   );

   // columns: command mask (1 enable, 2 open, 4 close), cycles to done, writes, rst, irq, thr
   localparam int NV = 6;
   localparam int VEC[NV][6] = '{
      '{1, W+2, 1, 1, 0, 0},
      '{2, W+8, 7, 7, 3, LVL},
      '{1, W+2, 1, 7, 3, LVL},
      '{4, 2,   1, 0, 3, LVL},
      '{6, 2,   1, 0, 3, LVL},
      '{3, W+8, 7, 7, 3, LVL}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_cmd(input int mask, input bit inject);
      int n;
      @(negedge clk);
      cmd_enable = mask[0];
      cmd_open   = mask[1];
      cmd_close  = mask[2];
      @(negedge clk);
      cmd_enable = 1'b0; cmd_open = 1'b0; cmd_close = 1'b0;
      n = 1; n_log = 0; mid_rst = -1; busy_low = 0;
      while (!done && n < 2000) begin
         if (wr_stb && n_log < 16) begin
            log_addr[n_log] = int'(wr_addr);
            log_data[n_log] = int'(wr_data);
            log_cyc[n_log]  = n;
            n_log++;
         end
         if (!busy) busy_low++;
         if (n == 5) mid_rst = int'(rst_reg);
         cmd_close = inject && (n == 3);
         @(negedge clk);
         n++;
      end
      cmd_close = 1'b0;
      cycles = n;
      check(busy == 1'b1, "R8 busy during done", int'(busy), 1);
      check(busy_low == 0, "R8 busy held", busy_low, 0);
      @(negedge clk);
      check(!busy && !done, "R8 idle after done", int'({busy, done}), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check(rst_reg == 0 && irq_ctrl == 0 && fifo_thr == 0, "R1 regs in reset", int'(rst_reg), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !wr_stb, "R1 flags after reset", int'({busy, done, wr_stb}), 0);
      check(rst_reg == 0, "R1 reset register", int'(rst_reg), 0);

      // table walk: R2 R6 R7 R9 R10
      for (int v = 0; v < NV; v++) begin
         run_cmd(VEC[v][0], 1'b0);
         check(cycles == VEC[v][1], "R2/R6/R7/R9 cycles to done", cycles, VEC[v][1]);
         check(n_log == VEC[v][2], "R9/R10 write count", n_log, VEC[v][2]);
         check(int'(rst_reg) == VEC[v][3], "R10 reset register", int'(rst_reg), VEC[v][3]);
         check(int'(irq_ctrl) == VEC[v][4], "R5 irq register", int'(irq_ctrl), VEC[v][4]);
         check(int'(fifo_thr) == VEC[v][5], "R6 threshold register", int'(fifo_thr), VEC[v][5]);
      end

      // early enable from 0: single write, R2
      run_cmd(4, 1'b0);
      run_cmd(1, 1'b0);
      check(n_log == 1 && log_addr[0] == 0 && log_data[0] == 1 && log_cyc[0] == 1,
            "R2 enable write", log_data[0], 1);
      check(mid_rst == 1, "R2 core released during wait", mid_rst, 1);

      // open with a close injected while busy: R3 R4 R5 R6 R9
      run_cmd(4, 1'b0);
      run_cmd(2, 1'b1);
      begin
         int ea[7] = '{0, 0, 0, 0, 0, 1, 2};
         int ed[7] = '{1, 0, 1, 3, 7, 3, LVL};
         int ec[7] = '{1, 2, W+3, W+4, W+5, W+6, W+7};
         check(n_log == 7, "R9 injected close ignored", n_log, 7);
         for (int k = 0; k < 7; k++) begin
            check(log_addr[k] == ea[k], "R4 write address order", log_addr[k], ea[k]);
            check(log_data[k] == ed[k], "R3/R4/R5/R6 write data order", log_data[k], ed[k]);
            check(log_cyc[k] == ec[k], "R3/R4 write cycle", log_cyc[k], ec[k]);
         end
      end
      check(mid_rst == 0, "R3 all parts held during wait", mid_rst, 0);
      check(rst_reg == 8'h07, "R9 reset register after ignored close", int'(rst_reg), 7);

      // close after full open: R7
      run_cmd(4, 1'b0);
      check(n_log == 1 && log_data[0] == 0 && log_cyc[0] == 1, "R7 close write", log_data[0], 0);
      check(rst_reg == 0 && irq_ctrl == 3 && fifo_thr == LVL, "R7 only reset register cleared",
            int'(rst_reg), 0);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule